// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block is a synthesizable stand-in for a word-wide static memory with an asynchronous-style control port. Five active-low controls (chip select, write strobe, output gate, and one enable per byte lane) are decoded on every cycle of a fast sampling clock into one of four modes: standby, read, write or outputs-off. The bidirectional data bus is split into an input word, an output word and a per-lane drive-enable vector. A pad ring or test fixture can join these into a real tri-state bus. A standby flag reports the power state that the controls select.

The controls are level-sensitive and are not a stream, so there is no valid/ready handshake and no back-pressure. The outputs follow the controls combinationally. A read sees the current memory contents at the current address. A write is open for as long as chip select and the write strobe are both low. On each cycle of that overlap the block latches the address, the data and the lane enables. The latched values are committed on the first clock edge at which the overlap has ended, whichever of the two signals rose to end it. The depth is a parameter, and the address width is derived from it.

Top module: `sram_emu_top`

## Requirements
- R1: With `cs_n` high, `dq_oe` is 2'b00, `dq_out` is zero and `sleep` is 1, for any value of the other controls. A write strobe given while deselected stores nothing.
- R2: With `cs_n` low and both lane enables high (`lane_n` = 2'b11), the block is in standby: `dq_oe` is 2'b00 and `sleep` is 1. A write window open in this state stores no lane.
- R3: Read (`cs_n`=0, `wr_n`=1, `rd_n`=0): `dq_oe[i]` is 1 exactly for the lanes with `lane_n[i]`=0. An enabled lane shows the stored byte of the current address. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R4: Write (`cs_n`=0, `wr_n`=0, at least one lane enabled): `dq_oe` is 2'b00 and `sleep` is 0, whatever the value of `rd_n`.
- R5: Outputs-off (`cs_n`=0, `wr_n`=1, `rd_n`=1, at least one lane enabled): `dq_oe` is 2'b00 and `sleep` is 0.
- R6: A write is committed at the first rising clock edge that samples the overlap of `cs_n` low and `wr_n` low as ended. It uses the address, data and lane enables sampled at the last edge of the overlap. Before that edge, a read of the address returns the old contents.
- R7: Only the lanes enabled at the last overlap edge are written. Every other lane keeps its old byte.
- R8: A write window ended by `cs_n` rising commits in the same way as one ended by `wr_n` rising.
- R9: If the data changes during the overlap, the value sampled at the last overlap edge is the one stored.
- R10: An asserted `rst_n` closes any open write window, so that window stores nothing.
- R11: A lane that is not driving has its `dq_out` byte at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the write tracker |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low output gate |
| lane_n | input | 2 | Active-low byte-lane enables (bit 0 = low byte) |
| addr | input | AW (10) | Word address |
| dq_in | input | 16 | Data presented by the bus for writes |
| dq_out | output | 16 | Data driven by the memory on reads |
| dq_oe | output | 2 | Per-lane drive enable for `dq_out` |
| sleep | output | 1 | 1 when the controls select standby |

## Verification
A write commit and a read can fall in the same cycle. This happens when the write strobe rises while the output gate is already low at the same address: that cycle reads, and its closing edge also commits the pending write. The bench provokes this case and checks, before the edge, that the lanes drive the old word. After the edge it checks that the merged new word appears. A second case overlaps a reset with the end of a write window, and the bench confirms that no commit leaks through.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_OUTOFF  = 2'd3
  } mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [LANES-1:0] lane_n,
  output mode_e            mode,
  output logic             overlap
);
  always_comb begin
    overlap = !cs_n && !wr_n;
    if (cs_n || (&lane_n)) mode = MODE_STANDBY;
    else if (!wr_n)        mode = MODE_WRITE;
    else if (!rd_n)        mode = MODE_READ;
    else                   mode = MODE_OUTOFF;
  end
endmodule

// File: rtl/sram_write_window.sv
module sram_write_window #(
  parameter int AW    = 10,
  parameter int LANES = 2,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             overlap,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic [LANES-1:0] lane_n,
  output logic             commit,
  output logic [AW-1:0]    hold_addr,
  output logic [DW-1:0]    hold_data,
  output logic [LANES-1:0] hold_en
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_en   <= '0;
    end else begin
      open_q <= overlap;
      if (overlap) begin
        hold_addr <= addr;
        hold_data <= din;
        hold_en   <= ~lane_n;
      end
    end
  end

  // The write lands on the first edge that sees the overlap gone.
  assign commit = open_q && !overlap;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             commit,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wen,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && wen[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/sram_emu_top.sv
module sram_emu_top
  import sram_emu_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] dq_oe,
  output logic             sleep
);
  mode_e             mode;
  logic              overlap;
  logic              commit;
  logic [AW-1:0]     hold_addr;
  logic [DW-1:0]     hold_data;
  logic [LANES-1:0]  hold_en;
  logic [DW-1:0]     rdata;

  sram_mode_decode #(.LANES(LANES)) u_dec (
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .lane_n(lane_n),
    .mode(mode), .overlap(overlap)
  );

  sram_write_window #(.AW(AW), .LANES(LANES), .DW(DW)) u_win (
    .clk(clk), .rst_n(rst_n), .overlap(overlap), .addr(addr),
    .din(dq_in), .lane_n(lane_n), .commit(commit),
    .hold_addr(hold_addr), .hold_data(hold_data), .hold_en(hold_en)
  );

  sram_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .commit(commit), .waddr(hold_addr), .wdata(hold_data),
    .wen(hold_en), .raddr(addr), .rdata(rdata)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    logic drive;
    assign drive    = (mode == MODE_READ) && !lane_n[g];
    assign dq_oe[g] = drive;
    assign dq_out[g*LANE_W +: LANE_W] = drive ? rdata[g*LANE_W +: LANE_W] : '0;
  end

  assign sleep = (mode == MODE_STANDBY);
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int AW     = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_n,
  input logic                    wr_n,
  input logic                    rd_n,
  input logic [LANES-1:0]        lane_n,
  input logic [AW-1:0]           addr,
  input logic [LANES*LANE_W-1:0] dq_out,
  input logic [LANES-1:0]        dq_oe,
  input logic                    sleep
);
  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == '0) && sleep);

  // R4
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n) |-> (dq_oe == '0));

  // R3
  lane_drive_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> (!cs_n && wr_n && !rd_n && ((dq_oe & lane_n) == '0)));

  // R5
  drive_means_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> !sleep);

  // R11
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe[0] |-> (dq_out[LANE_W-1:0] == '0));

  // R2
  lanes_off_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_n) |-> sleep);

  logic unused_addr;
  assign unused_addr = ^addr;
endmodule

bind sram_emu_top sram_emu_chk #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
  .lane_n(lane_n), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .sleep(sleep)
);

// File: tb/sim_sram_emu_top.sv
module sim_sram_emu_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int NVEC  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        sleep;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  sram_emu_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .lane_n(lane_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .sleep(sleep)
  );

  // Shadow model built from the requirements.
  logic [15:0]   shadow [16];
  logic          m_open = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0]   m_data = '0;
  logic [1:0]    m_en   = '0;

  // Vector: {cs,wr,rd,lane_n[1],lane_n[0]} addr4 din16 exp_oe2 exp_sleep
  localparam logic [27:0] VEC [NVEC] = '{
    {5'b10000, 4'd0, 16'hAAAA, 2'b00, 1'b1}, // R1 write strobe while deselected
    {5'b00000, 4'd1, 16'h1234, 2'b00, 1'b0}, // R4 full write
    {5'b01100, 4'd1, 16'h0000, 2'b00, 1'b0}, // R5 off, R6 commit
    {5'b01000, 4'd1, 16'h0000, 2'b11, 1'b0}, // R3 full read
    {5'b01010, 4'd1, 16'h0000, 2'b01, 1'b0}, // R3 low lane, R11
    {5'b01001, 4'd1, 16'h0000, 2'b10, 1'b0}, // R3 high lane, R11
    {5'b00110, 4'd1, 16'h00CD, 2'b00, 1'b0}, // R4 rd ignored
    {5'b00010, 4'd1, 16'h55EF, 2'b00, 1'b0}, // R9 last data wins
    {5'b01000, 4'd1, 16'h0000, 2'b11, 1'b0}, // R6 read during commit: old word
    {5'b01000, 4'd1, 16'h0000, 2'b11, 1'b0}, // R7 merged word
    {5'b00000, 4'd2, 16'h0F0F, 2'b00, 1'b0}, // R4
    {5'b10000, 4'd2, 16'h0000, 2'b00, 1'b1}, // R8 end by cs rising
    {5'b01000, 4'd2, 16'h0000, 2'b11, 1'b0}, // R8 readback
    {5'b00011, 4'd2, 16'hFFFF, 2'b00, 1'b1}, // R2 write with lanes off
    {5'b11011, 4'd2, 16'h0000, 2'b00, 1'b1}, // R1
    {5'b01000, 4'd2, 16'h0000, 2'b11, 1'b0}, // R2 nothing stored
    {5'b00101, 4'd2, 16'hA55A, 2'b00, 1'b0}, // R7 high lane only
    {5'b01100, 4'd2, 16'h0000, 2'b00, 1'b0}, // R5
    {5'b01000, 4'd2, 16'h0000, 2'b11, 1'b0}, // R7 readback
    {5'b01011, 4'd2, 16'h0000, 2'b00, 1'b1}  // R2 read with lanes off
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] ctl, input logic [3:0] a, input logic [15:0] d,
                      input logic [1:0] eoe, input logic esb);
    logic [15:0] edq;
    string tag;
    {cs_n, wr_n, rd_n, lane_n} = ctl;
    addr  = AW'(a);
    dq_in = d;
    #2;
    if (ctl[4])             tag = "R1";
    else if (&ctl[1:0])     tag = "R2";
    else if (!ctl[3])       tag = "R4";
    else if (!ctl[2])       tag = "R3";
    else                    tag = "R5";
    edq = {eoe[1] ? shadow[a][15:8] : 8'h00, eoe[0] ? shadow[a][7:0] : 8'h00};
    chk(tag, {14'd0, dq_oe}, {14'd0, eoe});
    chk(tag, {15'd0, sleep}, {15'd0, esb});
    chk("R7/R11 data", dq_out, edq);
    @(posedge clk);
    if (!rst_n) m_open = 1'b0;
    else begin
      if (m_open && !(!cs_n && !wr_n))
        for (int l = 0; l < 2; l++)
          if (m_en[l]) shadow[m_addr[3:0]][l*8 +: 8] = m_data[l*8 +: 8];
      if (!cs_n && !wr_n) begin
        m_addr = addr; m_data = dq_in; m_en = ~lane_n;
      end
      m_open = !cs_n && !wr_n;
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state: deselected and asleep (R1)
    #2;
    chk("R1 reset oe", {14'd0, dq_oe}, 16'd0);
    chk("R1 reset sleep", {15'd0, sleep}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      step(VEC[i][27:23], VEC[i][22:19], VEC[i][18:3], VEC[i][2:1], VEC[i][0]);

    // R10: reset during an open window discards it
    step(5'b00000, 4'd3, 16'h1111, 2'b00, 1'b0);
    step(5'b01100, 4'd3, 16'h0000, 2'b00, 1'b0);
    step(5'b00000, 4'd3, 16'h7777, 2'b00, 1'b0);
    rst_n = 1'b0;
    step(5'b01100, 4'd3, 16'h0000, 2'b00, 1'b0);
    rst_n = 1'b1;
    step(5'b01000, 4'd3, 16'h0000, 2'b11, 1'b0);
    chk("R10 no commit", dq_out, 16'h1111);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule